// File: doc/BRIEF.md
# Broadcast Output-Stationary Multiply-Accumulate Array

This block is a square-or-rectangular grid of multiply-accumulate cells that keeps every partial result where it is produced. On each accepted beat, one vector of 8-bit data operands is driven along the rows and one vector of 8-bit weight operands is driven along the columns. Every cell multiplies its own row operand by its own column operand and adds the product into a 30-bit local accumulator. No sum ever moves between cells while a pass is being accumulated.

A pass ends with a beat marked as final. On that edge every cell places its completed sum in a second per-cell register and restarts its accumulator at zero. The second registers then drain one row per cycle, lowest row first, through a row-wide result port that carries a valid flag and a row index. The next pass accumulates while this happens. If a pass tries to finish while an earlier drain still needs its registers, the array holds off with a busy flag and the source keeps the final beat on its inputs until the array takes it.

The grid size, operand width and accumulator width are parameters. The defaults are an 8x8 grid with 8-bit operands and 30-bit sums. Feeding the operands and consuming the result rows are outside this block.

Top module: `bcast_mac_array`

## Requirements
- R1: Each operand is 8 bits wide. It is read as two's complement when its vector's signedness input (`data_is_signed` or `wgt_is_signed`) is 1, and as unsigned when that input is 0. The signedness inputs are sampled on every beat.
- R2: The cell at row r, column c multiplies data element r (`data_vec[r*8 +: 8]`) by weight element c (`wgt_vec[c*8 +: 8]`). Column c of a result row appears on `res_row[c*30 +: 30]`.
- R3: Accumulation wraps modulo 2^30 and never saturates. A result equals the exact dot product reduced modulo 2^30.
- R4: A beat with `beat_first` high starts a new sum from its own product and discards whatever the accumulator held. An accepted beat with `beat_last` high has its product included in the result, which is captured on that edge while the accumulator restarts at zero. `res_valid` is high with `res_idx` = 0 in the cycle after that edge.
- R5: A captured pass leaves as rows 0, 1, ..., ROWS-1 on consecutive cycles. `res_valid` is high for exactly those ROWS cycles unless another pass is captured on the final row's edge.
- R6: A pass accumulated during an unload produces correct results. A pass may be captured on the edge that ends the final unload row, and its row 0 then follows the previous pass's last row without a gap.
- R7: `busy` is 1 exactly when an unload is in progress and the row on the port is not row ROWS-1. A beat with `beat_last` high presented while `busy` is 1 is not taken: no capture happens, the accumulators keep their values, and the unload continues with the next row.
- R8: After reset, `res_valid` and `busy` are 0 and every accumulator and capture register is zero, so a first pass without `beat_first` sums from zero.
- R9: Cycles with `beat_valid` low leave the accumulators unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| beat_valid | input | 1 | Operand vectors and controls are valid this cycle |
| beat_first | input | 1 | This beat opens a new sum |
| beat_last | input | 1 | This beat closes the pass |
| data_is_signed | input | 1 | Data operands are two's complement |
| wgt_is_signed | input | 1 | Weight operands are two's complement |
| data_vec | input | ROWS*8 | Data operands, one per row |
| wgt_vec | input | COLS*8 | Weight operands, one per column |
| busy | output | 1 | A final beat would not be taken this cycle |
| res_valid | output | 1 | A result row is on `res_row` |
| res_idx | output | clog2(ROWS) | Row number of the result on the port |
| res_row | output | COLS*30 | One row of results, column 0 in the low bits |

## Verification
The bench goes after these corner cases:
- A long run of all-ones unsigned operands pushes every sum past 2^30. A design that saturates or drops carries would report values other than the wrapped sum.
- Single-beat passes arrive back to back, so final beats meet the busy window and the final-row edge. A design that overwrote live capture registers would corrupt rows still being drained. A design that accepted a stalled beat would count its product twice.
- A mid-pass restart with `beat_first` checks that stale partial sums are discarded.
- Idle cycles carry random operands. Any leakage from them shows up as a wrong dot product.
- Mixed signedness per beat and per vector checks both operand modes. A cell that indexes the wrong row or column, or sign-extends wrongly, mismatches the bench's per-cell dot products.

// File: rtl/mac_grid_pkg.sv
// Package: shared widths for the broadcast MAC grid.
// Assumes: the accumulator is at least as wide as a full product.
package mac_grid_pkg;
    localparam int unsigned OPW_DEF  = 8;   // operand width
    localparam int unsigned ACCW_DEF = 30;  // accumulator width

    // Control fields carried by one operand beat.
    typedef struct packed {
        logic first;
        logic last;
        logic d_sgn;
        logic w_sgn;
    } beat_ctl_t;
endpackage

// File: rtl/mac_cell.sv
// Module: mac_cell
// One output-stationary multiply-accumulate cell. Multiplies a broadcast data
// operand by a broadcast weight operand and adds the product into a local
// accumulator. On a closing beat it moves the finished sum into its capture
// register and restarts the accumulator. The capture register also forms one
// stage of a column shift chain toward the output port.
// Assumes: ACCW >= 2*OPW + 2; capture and shift never request the same edge
// (capture wins if they do).
module mac_cell #(
    parameter int unsigned OPW  = 8,
    parameter int unsigned ACCW = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic            step_first,
    input  logic            step_capture,
    input  logic            shift_en,
    input  logic            d_sgn,
    input  logic            w_sgn,
    input  logic [OPW-1:0]  d_op,
    input  logic [OPW-1:0]  w_op,
    input  logic [ACCW-1:0] chain_in,
    output logic [ACCW-1:0] chain_out
);
    localparam int unsigned PW = 2*OPW + 2;

    logic signed [OPW:0]    d_ext;
    logic signed [OPW:0]    w_ext;
    logic signed [PW-1:0]   prod;
    logic        [ACCW-1:0] prod_ext;
    logic        [ACCW-1:0] acc_q;
    logic        [ACCW-1:0] cap_q;
    logic        [ACCW-1:0] sum;

    // Extend each operand by one bit according to its signedness flag.
    always_comb begin
        d_ext    = {d_sgn & d_op[OPW-1], d_op};
        w_ext    = {w_sgn & w_op[OPW-1], w_op};
        prod     = PW'(d_ext) * PW'(w_ext);
        prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
        sum      = (step_first ? '0 : acc_q) + prod_ext;
    end

    // Accumulator: adds the product, restarts on capture, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_en) begin
            acc_q <= step_capture ? '0 : sum;
        end
    end

    // Capture register: takes the finished sum, otherwise shifts toward the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (step_en && step_capture) begin
            cap_q <= sum;
        end else if (shift_en) begin
            cap_q <= chain_in;
        end
    end

    assign chain_out = cap_q;
endmodule

// File: rtl/mac_unload_ctrl.sv
// Module: mac_unload_ctrl
// Tracks the drain of captured rows. A capture starts the drain at row 0; each
// following cycle advances one row until row ROWS-1 has been shown. Busy is
// raised while a capture would overwrite rows that have not yet left.
// Assumes: load is only asserted when busy is low.
module mac_unload_ctrl #(
    parameter int unsigned ROWS = 8,
    parameter int unsigned IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    output logic            active,
    output logic [IDXW-1:0] row_idx,
    output logic            shift_en,
    output logic            busy
);
    localparam logic [IDXW-1:0] LAST_ROW = IDXW'(ROWS - 1);

    logic on_last;

    // The final row frees the capture registers on the edge that ends it.
    always_comb begin
        on_last  = (row_idx == LAST_ROW);
        busy     = active && !on_last;
        shift_en = active;
    end

    // Drain state: start on load, step each cycle, stop after the final row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            row_idx <= '0;
        end else if (load) begin
            active  <= 1'b1;
            row_idx <= '0;
        end else if (active) begin
            if (on_last) begin
                active  <= 1'b0;
                row_idx <= '0;
            end else begin
                row_idx <= row_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcast_mac_array.sv
// Module: bcast_mac_array (top)
// A ROWS x COLS grid of output-stationary MAC cells fed by broadcast operand
// vectors. It captures finished sums into per-cell shift registers and drains
// them one row per cycle while the next pass accumulates.
// Assumes: the source holds a closing beat on its inputs while busy is high.
module bcast_mac_array
    import mac_grid_pkg::*;
#(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 8,
    parameter int unsigned OPW  = OPW_DEF,
    parameter int unsigned ACCW = ACCW_DEF,
    parameter int unsigned IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_valid,
    input  logic                 beat_first,
    input  logic                 beat_last,
    input  logic                 data_is_signed,
    input  logic                 wgt_is_signed,
    input  logic [ROWS*OPW-1:0]  data_vec,
    input  logic [COLS*OPW-1:0]  wgt_vec,
    output logic                 busy,
    output logic                 res_valid,
    output logic [IDXW-1:0]      res_idx,
    output logic [COLS*ACCW-1:0] res_row
);
    beat_ctl_t   ctl;
    logic        step_en;
    logic        load;
    logic        shift_en;
    logic        busy_w;
    logic        active;
    logic [IDXW-1:0] row_idx;

    // Chain wires: chain[r][c] is the capture value of cell (r,c); row ROWS is zero fill.
    logic [ACCW-1:0] chain [ROWS+1][COLS];

    // Gather the beat controls and decide whether this beat is taken.
    always_comb begin
        ctl.first = beat_first;
        ctl.last  = beat_last;
        ctl.d_sgn = data_is_signed;
        ctl.w_sgn = wgt_is_signed;
        step_en   = beat_valid && !(ctl.last && busy_w);
        load      = step_en && ctl.last;
    end

    mac_unload_ctrl #(
        .ROWS (ROWS),
        .IDXW (IDXW)
    ) u_unload (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .active   (active),
        .row_idx  (row_idx),
        .shift_en (shift_en),
        .busy     (busy_w)
    );

    genvar gr, gc;
    generate
        for (gc = 0; gc < COLS; gc++) begin : g_fill
            assign chain[ROWS][gc] = '0;
        end
        for (gr = 0; gr < ROWS; gr++) begin : g_row
            for (gc = 0; gc < COLS; gc++) begin : g_col
                mac_cell #(
                    .OPW  (OPW),
                    .ACCW (ACCW)
                ) u_cell (
                    .clk          (clk),
                    .rst_n        (rst_n),
                    .step_en      (step_en),
                    .step_first   (ctl.first),
                    .step_capture (ctl.last),
                    .shift_en     (shift_en),
                    .d_sgn        (ctl.d_sgn),
                    .w_sgn        (ctl.w_sgn),
                    .d_op         (data_vec[gr*OPW +: OPW]),
                    .w_op         (wgt_vec[gc*OPW +: OPW]),
                    .chain_in     (chain[gr+1][gc]),
                    .chain_out    (chain[gr][gc])
                );
            end
            if (gr == 0) begin : g_port
                for (gc = 0; gc < COLS; gc++) begin : g_out
                    assign res_row[gc*ACCW +: ACCW] = chain[0][gc];
                end
            end
        end
    endgenerate

    assign busy      = busy_w;
    assign res_valid = active;
    assign res_idx   = row_idx;
endmodule

// File: rtl/bcast_mac_array_chk.sv
// Module: bcast_mac_array_chk
// Protocol checker for the unload sequencing and stall rule, attached by bind.
module bcast_mac_array_chk #(
    parameter int unsigned ROWS = 8,
    parameter int unsigned IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            beat_valid,
    input logic            beat_last,
    input logic            busy,
    input logic            res_valid,
    input logic [IDXW-1:0] res_idx
);
    logic take_last;
    logic fin_row;
    assign take_last = beat_valid && beat_last && !busy;
    assign fin_row   = (res_idx == IDXW'(ROWS - 1));

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !res_valid && !busy); // R8
    AST_CAPTURE_START: assert property (@(posedge clk) disable iff (!rst_n)
        take_last |=> res_valid && res_idx == '0); // R4
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !fin_row |=> res_valid && res_idx == $past(res_idx) + 1'b1); // R5
    AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && fin_row && !take_last |=> !res_valid); // R5
    AST_BUSY_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> res_valid && !fin_row); // R7
    AST_STALL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy && beat_valid && beat_last |=> res_idx != '0); // R7
endmodule

bind bcast_mac_array bcast_mac_array_chk #(
    .ROWS (ROWS),
    .IDXW (IDXW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_idx    (res_idx)
);

// File: tb/sim_bcast_mac_array.sv
module sim_bcast_mac_array;
    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int OPW  = 8;
    localparam int ACCW = 30;
    localparam int IDXW = 3;
    localparam int SNAPW = ROWS*COLS*ACCW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic beat_valid = 1'b0, beat_first = 1'b0, beat_last = 1'b0;
    logic data_is_signed = 1'b0, wgt_is_signed = 1'b0;
    logic [ROWS*OPW-1:0] data_vec = '0;
    logic [COLS*OPW-1:0] wgt_vec = '0;
    logic busy, res_valid;
    logic [IDXW-1:0] res_idx;
    logic [COLS*ACCW-1:0] res_row;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    string tag = "R8";

    logic [ACCW-1:0] acc_m [ROWS][COLS];
    logic [SNAPW-1:0] exp_q [$];
    int exp_row = 0;

    always #5 clk = ~clk;

    bcast_mac_array u0 (.*);

    // Product of two operands under the signedness rule of R1, reduced to 30 bits.
    function automatic logic [ACCW-1:0] prod30(logic [7:0] a, logic [7:0] b, bit sa, bit sb);
        int ia;
        int ib;
        int p;
        ia = sa ? int'($signed(a)) : int'(a);
        ib = sb ? int'($signed(b)) : int'(b);
        p  = ia * ib;
        return p[ACCW-1:0];
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one beat; return whether the array took it and update the model.
    task automatic beat(bit v, bit f, bit l, bit ds, bit ws,
                        logic [ROWS*OPW-1:0] d, logic [COLS*OPW-1:0] w, output bit took);
        bit b;
        logic [SNAPW-1:0] snap;
        @(negedge clk);
        b = busy;
        beat_valid = v; beat_first = f; beat_last = l;
        data_is_signed = ds; wgt_is_signed = ws;
        data_vec = d; wgt_vec = w;
        took = v && !(l && b);
        @(posedge clk);
        if (took) begin
            snap = '0;
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    logic [ACCW-1:0] s;
                    s = (f ? '0 : acc_m[r][c]) + prod30(d[r*OPW +: OPW], w[c*OPW +: OPW], ds, ws);
                    if (l) begin
                        snap[((r*COLS)+c)*ACCW +: ACCW] = s;
                        acc_m[r][c] = '0;
                    end else begin
                        acc_m[r][c] = s;
                    end
                end
            end
            if (l) exp_q.push_back(snap);
        end
    endtask

    function automatic logic [ROWS*OPW-1:0] rnd_d();
        logic [ROWS*OPW-1:0] x;
        for (int i = 0; i < ROWS; i++) x[i*OPW +: OPW] = 8'($urandom);
        return x;
    endfunction

    function automatic logic [COLS*OPW-1:0] rnd_w();
        logic [COLS*OPW-1:0] x;
        for (int i = 0; i < COLS; i++) x[i*OPW +: OPW] = 8'($urandom);
        return x;
    endfunction

    // Closing beat: retried until taken (R7 stall rule exercised on every retry).
    task automatic close_pass(bit f, bit ds, bit ws);
        bit took;
        logic [ROWS*OPW-1:0] d;
        logic [COLS*OPW-1:0] w;
        d = rnd_d(); w = rnd_w();
        took = 1'b0;
        while (!took) beat(1'b1, f, 1'b1, ds, ws, d, w, took);
    endtask

    task automatic rnd_pass(int len, bit idle_gaps);
        bit took;
        for (int k = 0; k < len - 1; k++) begin
            if (idle_gaps && ($urandom % 3 == 0))
                beat(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rnd_d(), rnd_w(), took); // R9
            beat(1'b1, k == 0, 1'b0, 1'($urandom), 1'($urandom), rnd_d(), rnd_w(), took);
        end
        close_pass(len == 1, 1'($urandom), 1'($urandom));
    endtask

    // Monitor: result rows against the model (R2, R5), busy against R7.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            chk(busy == (res_valid && res_idx != IDXW'(ROWS-1)), "R7", "busy", busy, res_valid);
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected row", res_idx, -1);
                end else begin
                    chk(res_idx == IDXW'(exp_row), "R5", "row index", res_idx, exp_row);
                    for (int c = 0; c < COLS; c++)
                        chk(res_row[c*ACCW +: ACCW] == exp_q[0][((exp_row*COLS)+c)*ACCW +: ACCW],
                            tag, $sformatf("R2 cell row %0d col %0d", exp_row, c),
                            res_row[c*ACCW +: ACCW], exp_q[0][((exp_row*COLS)+c)*ACCW +: ACCW]);
                    exp_row++;
                    if (exp_row == ROWS) begin
                        exp_row = 0;
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        bit took;
        void'($urandom(32'd2024));
        for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) acc_m[r][c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R8", "res_valid in reset", res_valid, 0);
        chk(busy == 1'b0, "R8", "busy in reset", busy, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R8", "res_valid after reset", res_valid, 0);

        // R8: first pass without beat_first sums from the cleared accumulators.
        tag = "R8";
        beat(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, rnd_d(), rnd_w(), took);
        close_pass(1'b0, 1'b0, 1'b1);

        // R4: stale partial sum discarded by a mid-pass beat_first.
        tag = "R4";
        for (int k = 0; k < 4; k++) beat(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, rnd_d(), rnd_w(), took);
        beat(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, rnd_d(), rnd_w(), took);
        close_pass(1'b0, 1'b1, 1'b0);

        // R1: signed extremes in each mode.
        tag = "R1";
        beat(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, {ROWS{8'h80}}, {COLS{8'h80}}, took);
        beat(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, {ROWS{8'h80}}, {COLS{8'hFF}}, took);
        beat(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, {ROWS{8'hFF}}, {COLS{8'h7F}}, took);
        close_pass(1'b0, 1'b1, 1'b1);

        // R9: idle beats with random payload between valid beats.
        tag = "R9";
        rnd_pass(12, 1'b1);

        // R6/R7: back-to-back single-beat passes overlap the drain and stall.
        tag = "R6";
        for (int p = 0; p < 12; p++) rnd_pass(1, 1'b0);
        for (int p = 0; p < 6; p++) rnd_pass(ROWS, 1'b0);

        // R2/R1: random passes of random length.
        tag = "R2";
        for (int p = 0; p < 60; p++) rnd_pass(1 + int'($urandom % 24), 1'($urandom));

        // R3: all-ones unsigned run wraps past 2^30.
        tag = "R3";
        for (int k = 0; k < 16599; k++)
            beat(1'b1, k == 0, 1'b0, 1'b0, 1'b0, {ROWS{8'hFF}}, {COLS{8'hFF}}, took);
        begin
            bit t2;
            t2 = 1'b0;
            while (!t2) beat(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {ROWS{8'hFF}}, {COLS{8'hFF}}, t2);
        end
        // R3: negative running sum wraps to large unsigned values.
        beat(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, {ROWS{8'h80}}, {COLS{8'hFF}}, took);
        close_pass(1'b0, 1'b1, 1'b0);

        @(negedge clk);
        beat_valid = 1'b0;
        repeat (3 * ROWS) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "rows left undrained", exp_q.size(), 0);
        chk(res_valid == 1'b0, "R5", "res_valid after drain", res_valid, 0);
        finish_up();
    end
endmodule